// File: doc/BRIEF.md
# Scan-Count Key Debouncer with Edge Events

This block sits behind a keypad matrix scanner. Each time the scanner finishes a pass over the whole key array, it presents a snapshot of all key levels and strobes a scan-complete input. For every key, the block compares the snapshot level with the key's accepted (debounced) level. A differing level is taken over only after it has been seen on a programmable number of back-to-back array scans, from one to four. Settling time is therefore counted in whole scans, not in clock cycles.

Up to 48 keys are held in a row-major layout: key index = row × COLS + column. With the default 6 × 8 matrix the lower 32 bits and the upper 16 bits of the vector cover rows 0–3 and rows 4–5. When the accepted level of a key changes, the block raises a one-cycle press or release pulse for that key. The configured number of rows and columns defines the live region of the matrix. Keys outside it are held released and stay silent. Scanning the matrix, latching event flags and raising interrupts belong to neighbouring blocks.

Top module: `kdb_debounce_top`

## Requirements
- R1: While reset is asserted and right after it, every bit of `key_state` is 1 (released) and `press_evt` and `release_evt` are all zero. Asserting reset at any time returns all keys to released.
- R2: `db_sel` selects how many consecutive scans a differing level must be seen before it is accepted: code 0 → 1 scan, 1 → 2, 2 → 3, 3 → 4.
- R3: A `key_state` bit changing from 1 to 0 (pressed) raises the matching `press_evt` bit for exactly one clock cycle. The pulse appears in the cycle after the clock edge that sampled `scan_done` high, together with the new state.
- R4: A `key_state` bit changing from 0 to 1 caused by the snapshot raises the matching `release_evt` bit for exactly one cycle, with the same timing as R3.
- R5: A scan whose sampled level equals a key's accepted level clears that key's agreement count. A later differing level must again be seen for the full number of scans.
- R6: On a clock edge where `scan_done` is low, `key_state` keeps its value and no event pulse is produced, whatever `snap_in` shows.
- R7: A key at row r and column c is live when r < `cfg_rows` and c < `cfg_cols`. On every scan, a key that is not live is set to released with its count cleared, and produces neither a press nor a release event, even if it was pressed before.
- R8: A key never shows a press and a release event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_done | input | 1 | One-cycle strobe: `snap_in` holds a complete array snapshot |
| snap_in | input | 48 | Raw key levels, 0 = pressed, index = row × 8 + column |
| db_sel | input | 2 | Consecutive-scan select, n = code + 1 |
| cfg_rows | input | 3 | Number of live rows (0..6) |
| cfg_cols | input | 4 | Number of live columns (0..8) |
| key_state | output | 48 | Debounced key levels, 0 = pressed, 1 = released |
| press_evt | output | 48 | Per-key one-cycle press pulses |
| release_evt | output | 48 | Per-key one-cycle release pulses |

## Verification
The bound checker checks these on every cycle:
- every falling state bit comes with a press pulse and no other press pulse appears;
- release pulses only accompany rising bits;
- the two event vectors never overlap;
- nothing moves without a scan strobe;
- keys outside the configured region are released and silent after each scan.

Only the bench's scan sequences can show the counting behaviour. This covers acceptance after exactly one, two, three or four agreeing scans under each select code, and the restart of the count when a matching scan breaks a run. It also covers the silent forcing of a pressed key to released when the region shrinks.

// File: rtl/kdb_pkg.sv
package kdb_pkg;
  // Consecutive-scan select codes; accepted after (code + 1) agreeing scans.
  typedef enum logic [1:0] {
    DB_ONE_SCAN   = 2'd0,
    DB_TWO_SCANS  = 2'd1,
    DB_THREE_SCANS = 2'd2,
    DB_FOUR_SCANS = 2'd3
  } db_sel_e;

  localparam logic KEY_RELEASED = 1'b1;
  localparam logic KEY_PRESSED  = 1'b0;
endpackage

// File: rtl/kdb_region_mask.sv
module kdb_region_mask #(
  parameter int ROWS = 6,
  parameter int COLS = 8
) (
  input  logic [$clog2(ROWS+1)-1:0] cfg_rows,
  input  logic [$clog2(COLS+1)-1:0] cfg_cols,
  output logic [ROWS*COLS-1:0]      live
);
  localparam int RW = $clog2(ROWS+1);
  localparam int CW = $clog2(COLS+1);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign live[r*COLS+c] = (RW'(r) < cfg_rows) && (CW'(c) < cfg_cols);
    end
  end
endmodule

// File: rtl/kdb_key_cell.sv
module kdb_key_cell
  import kdb_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_done,
  input  logic             live,
  input  logic             sample,
  input  logic [CNT_W-1:0] limit,
  output logic             state,
  output logic             press,
  output logic             release_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             state_n, press_n, release_n;

  always_comb begin
    state_n   = state;
    cnt_n     = cnt_q;
    press_n   = 1'b0;
    release_n = 1'b0;
    if (scan_done) begin
      if (!live) begin
        state_n = KEY_RELEASED;
        cnt_n   = '0;
      end else if (sample == state) begin
        cnt_n = '0;
      end else if (cnt_q >= limit) begin
        state_n   = sample;
        cnt_n     = '0;
        press_n   = (sample == KEY_PRESSED);
        release_n = (sample == KEY_RELEASED);
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= KEY_RELEASED;
      cnt_q     <= '0;
      press     <= 1'b0;
      release_o <= 1'b0;
    end else begin
      state     <= state_n;
      cnt_q     <= cnt_n;
      press     <= press_n;
      release_o <= release_n;
    end
  end
endmodule

// File: rtl/kdb_debounce_top.sv
module kdb_debounce_top #(
  parameter int ROWS  = 6,
  parameter int COLS  = 8,
  parameter int CNT_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scan_done,
  input  logic [ROWS*COLS-1:0]      snap_in,
  input  logic [CNT_W-1:0]          db_sel,
  input  logic [$clog2(ROWS+1)-1:0] cfg_rows,
  input  logic [$clog2(COLS+1)-1:0] cfg_cols,
  output logic [ROWS*COLS-1:0]      key_state,
  output logic [ROWS*COLS-1:0]      press_evt,
  output logic [ROWS*COLS-1:0]      release_evt
);
  localparam int NKEYS = ROWS * COLS;

  logic [NKEYS-1:0] live;

  kdb_region_mask #(.ROWS(ROWS), .COLS(COLS)) mask_i (
    .cfg_rows (cfg_rows),
    .cfg_cols (cfg_cols),
    .live     (live)
  );

  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    kdb_key_cell #(.CNT_W(CNT_W)) cell_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .scan_done (scan_done),
      .live      (live[k]),
      .sample    (snap_in[k]),
      .limit     (db_sel),
      .state     (key_state[k]),
      .press     (press_evt[k]),
      .release_o (release_evt[k])
    );
  end
endmodule

// File: rtl/kdb_debounce_chk.sv
module kdb_debounce_chk #(
  parameter int ROWS  = 6,
  parameter int COLS  = 8,
  parameter int CNT_W = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      scan_done,
  input logic [ROWS*COLS-1:0]      snap_in,
  input logic [CNT_W-1:0]          db_sel,
  input logic [$clog2(ROWS+1)-1:0] cfg_rows,
  input logic [$clog2(COLS+1)-1:0] cfg_cols,
  input logic [ROWS*COLS-1:0]      key_state,
  input logic [ROWS*COLS-1:0]      press_evt,
  input logic [ROWS*COLS-1:0]      release_evt
);
  localparam int NKEYS = ROWS * COLS;

  logic [NKEYS-1:0] exp_live;
  logic             unused_ok;

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        exp_live[r*COLS+c] = (r < int'(cfg_rows)) && (c < int'(cfg_cols));
      end
    end
  end

  assign unused_ok = ^{snap_in, db_sel};

  // R3: falling state bits and press pulses coincide exactly
  a_r3_press_matches_fall: assert property (@(posedge clk) disable iff (!rst_n)
    press_evt == ($past(key_state) & ~key_state));

  // R4: a release pulse only accompanies a rising state bit
  a_r4_release_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (release_evt & ~(~$past(key_state) & key_state)) == '0);

  // R8: never both events on one key
  a_r8_evt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (press_evt & release_evt) == '0);

  // R6: no strobe, no movement
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_done |=> ($stable(key_state) && press_evt == '0 && release_evt == '0));

  // R7: keys outside the live region are released and silent after a scan
  a_r7_outside_released: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> (((key_state | $past(exp_live)) == '1) &&
                   (((press_evt | release_evt) & ~$past(exp_live)) == '0)));
endmodule

bind kdb_debounce_top kdb_debounce_chk #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .scan_done   (scan_done),
  .snap_in     (snap_in),
  .db_sel      (db_sel),
  .cfg_rows    (cfg_rows),
  .cfg_cols    (cfg_cols),
  .key_state   (key_state),
  .press_evt   (press_evt),
  .release_evt (release_evt)
);

// File: tb/kdb_debounce_top_tb_top.sv
`timescale 1ns/1ps
module kdb_debounce_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        scan_done;
  logic [47:0] snap_in;
  logic [1:0]  db_sel;
  logic [2:0]  cfg_rows;
  logic [3:0]  cfg_cols;
  logic [47:0] key_state, press_evt, release_evt;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  kdb_debounce_top dut_i (
    .clk (clk), .rst_n (rst_n), .scan_done (scan_done), .snap_in (snap_in),
    .db_sel (db_sel), .cfg_rows (cfg_rows), .cfg_cols (cfg_cols),
    .key_state (key_state), .press_evt (press_evt), .release_evt (release_evt)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [47:0] snap;
    logic [47:0] st;
    logic [47:0] pr;
    logic [47:0] rl;
  } vec_t;

  localparam vec_t TBL [0:17] = '{
    '{2'd0, 48'hFFFF_FFFF_FFFE, 48'hFFFF_FFFF_FFFE, 48'h1,              48'h0},  // R2 n=1 press
    '{2'd0, 48'hFFFF_FFFF_FFFE, 48'hFFFF_FFFF_FFFE, 48'h0,              48'h0},
    '{2'd0, 48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF, 48'h0,              48'h1},  // R4
    '{2'd1, 48'h7FFF_FFFF_FFF0, 48'hFFFF_FFFF_FFFF, 48'h0,              48'h0},  // R2 n=2
    '{2'd1, 48'h7FFF_FFFF_FFF0, 48'h7FFF_FFFF_FFF0, 48'h8000_0000_000F, 48'h0},
    '{2'd1, 48'hFFFF_FFFF_FFFF, 48'h7FFF_FFFF_FFF0, 48'h0,              48'h0},  // R5
    '{2'd1, 48'h7FFF_FFFF_FFF0, 48'h7FFF_FFFF_FFF0, 48'h0,              48'h0},
    '{2'd1, 48'hFFFF_FFFF_FFFF, 48'h7FFF_FFFF_FFF0, 48'h0,              48'h0},
    '{2'd1, 48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF, 48'h0,              48'h8000_0000_000F},
    '{2'd3, 48'hFFFF_FFFF_00FF, 48'hFFFF_FFFF_FFFF, 48'h0,              48'h0},  // R2 n=4
    '{2'd3, 48'hFFFF_FFFF_00FF, 48'hFFFF_FFFF_FFFF, 48'h0,              48'h0},
    '{2'd3, 48'hFFFF_FFFF_00FF, 48'hFFFF_FFFF_FFFF, 48'h0,              48'h0},
    '{2'd3, 48'hFFFF_FFFF_00FF, 48'hFFFF_FFFF_00FF, 48'hFF00,           48'h0},
    '{2'd2, 48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_00FF, 48'h0,              48'h0},  // R2 n=3, R5
    '{2'd2, 48'hFFFF_FFFF_00FF, 48'hFFFF_FFFF_00FF, 48'h0,              48'h0},
    '{2'd2, 48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_00FF, 48'h0,              48'h0},
    '{2'd2, 48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_00FF, 48'h0,              48'h0},
    '{2'd2, 48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF, 48'h0,              48'hFF00}
  };

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_scan(input logic [1:0] sel, input logic [47:0] snap);
    @(negedge clk);
    db_sel    = sel;
    snap_in   = snap;
    scan_done = 1'b1;
    @(negedge clk);
    scan_done = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; scan_done = 1'b0; snap_in = '1; db_sel = 2'd0;
    cfg_rows = 3'd6; cfg_cols = 4'd8;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 state in reset", key_state, '1);
    chk("R1 events in reset", press_evt | release_evt, '0);
    rst_n = 1'b1;

    for (int i = 0; i < 18; i++) begin
      do_scan(TBL[i].sel, TBL[i].snap);
      chk($sformatf("R2/R5 state step %0d", i), key_state, TBL[i].st);
      chk($sformatf("R3 press step %0d", i), press_evt, TBL[i].pr);
      chk($sformatf("R4 release step %0d", i), release_evt, TBL[i].rl);
      chk($sformatf("R8 overlap step %0d", i), press_evt & release_evt, '0);
      @(negedge clk);
      chk($sformatf("R3/R4 pulse width step %0d", i), press_evt | release_evt, '0);
    end

    // R6: snapshot moves without strobe
    snap_in = '0;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      chk("R6 state held without strobe", key_state, '1);
      chk("R6 no events without strobe", press_evt | release_evt, '0);
    end

    // R7: 2 rows x 3 cols live, all keys pressed in snapshot
    cfg_rows = 3'd2; cfg_cols = 4'd3;
    do_scan(2'd0, 48'h0);
    chk("R7 live region pressed", key_state, 48'hFFFF_FFFF_F8F8);
    chk("R7 press only in region", press_evt, 48'h707);
    // shrink to one key: pressed keys outside go released silently
    cfg_rows = 3'd1; cfg_cols = 4'd1;
    do_scan(2'd0, 48'h0);
    chk("R7 forced released", key_state, 48'hFFFF_FFFF_FFFE);
    chk("R7 no release on forcing", release_evt, '0);
    chk("R7 no press on forcing", press_evt, '0);

    // R1: reset from a pressed state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset releases keys", key_state, '1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state after reset", key_state, '1);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      finish_run();
    end
  end
endmodule